// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor that finishes one instruction in each clock cycle. It has no pipeline. It runs a compact subset of a classic 32-bit load/store instruction set. Every instruction is one 32-bit word, and its top six bits are the opcode. The core decodes three layouts: a register layout (opcode 0, with a function code in the low six bits), an immediate layout with a 16-bit constant, and a jump layout with a 26-bit word index. The core holds thirty-two 32-bit registers, and register 0 is fixed at zero. Data memory is a small word array inside the core.

Instructions come from a word-addressed memory. The integrator fills it through a write port while the `halt` input is high. When `halt` drops, the core starts executing from address 0 and advances once per clock. Two debug read ports return a register or a data word one clock after the address is presented, so the final architectural state can be compared with a model.

Top module: `mrc_core`

## Requirements
- R1: After synchronous reset the program counter (`pc_out`) is 0, and all general registers read as 0.
- R2: Register 0 always reads as zero, and any write aimed at it is discarded.
- R3: Register-layout operations select by function code: add 32 and addu 33 both give a wrapping 32-bit sum; sub 34 and subu 35 both give a wrapping difference rs−rt; and 36, or 37 and nor 39 are bitwise. The result is written to rd (bits 15:11).
- R4: slt (function 42) writes 1 to rd when rs < rt as signed values, else 0. sltu (43) compares the same way as unsigned values. slti (opcode 10) and sltiu (opcode 11) compare rs with the sign-extended immediate and write the result to rt.
- R5: sll (function 0) and srl (function 2) shift rt by the 5-bit amount in bits 10:6. srl fills with zeros.
- R6: Immediate operations write to rt (bits 20:16). addi 8 and addiu 9 add the sign-extended immediate. andi 12 and ori 13 use the zero-extended immediate. lui 15 writes the immediate to bits 31:16 and clears bits 15:0.
- R7: lw (opcode 35) and sw (opcode 43) access the data word at byte address rs + sign-extended offset. lw writes rt; sw stores rt and writes no register.
- R8: beq (opcode 4) and bne (opcode 5) compare rs with rt. When the branch is taken, the next PC is PC+4 + (sign-extended offset × 4). Otherwise the next PC is PC+4.
- R9: j (opcode 2) and jal (opcode 3) jump to {PC+4[31:28], index26, 00}. jal also writes PC+4 into register 31. jr (function 8) loads the PC from rs.
- R10: An unknown opcode or an unknown register-layout function code changes no state except PC ← PC+4.
- R11: While `halt` is high, the PC, the registers and the data memory hold their values. The debug ports return the addressed register or data word on the clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freezes execution while high |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_waddr | input | IMEM_AW | Instruction word index to write |
| imem_wdata | input | 32 | Instruction word to write |
| dbg_reg_addr | input | 5 | Register to read back |
| dbg_reg_data | output | 32 | Registered register read-back |
| dbg_mem_addr | input | DMEM_AW | Data word index to read back |
| dbg_mem_data | output | 32 | Registered data word read-back |
| pc_out | output | 32 | Current program counter |

## Verification
A wrong next-PC computation shows up on `pc_out` at the very next clock. This covers a bad branch offset, a wrong jump splice or a missed jr, and the bench compares the PC with a behavioural model every cycle. A wrong ALU result, the wrong destination field, or a stray write to register 0 stays hidden in the register array. It surfaces only through the debug port after halting, or sooner when a later branch or jr consumes the bad value and the PC diverges. A store to the wrong word is seen only by reading data memory back.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_ADDIU = 6'd9;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_SLTIU = 6'd11;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC4} wb_sel_e;

  typedef struct packed {
    alu_op_e  alu_op;
    logic     use_imm;
    logic     imm_zext;
    logic     reg_we;
    dst_sel_e dst;
    wb_sel_e  wb;
    logic     mem_we;
    logic     br_eq;
    logic     br_ne;
    logic     jump;
    logic     jreg;
  } ctrl_t;
endpackage

// File: rtl/mrc_decode.sv
module mrc_decode
  import mrc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [5:0] opc;
  logic [5:0] fn;
  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctrl          = '0;
    ctrl.alu_op   = ALU_ADD;
    ctrl.dst      = DST_RD;
    ctrl.wb       = WB_ALU;
    unique case (opc)
      OP_RTYPE: begin
        ctrl.reg_we = 1'b1;
        unique case (fn)
          FN_ADD, FN_ADDU: ctrl.alu_op = ALU_ADD;
          FN_SUB, FN_SUBU: ctrl.alu_op = ALU_SUB;
          FN_AND:          ctrl.alu_op = ALU_AND;
          FN_OR:           ctrl.alu_op = ALU_OR;
          FN_NOR:          ctrl.alu_op = ALU_NOR;
          FN_SLT:          ctrl.alu_op = ALU_SLT;
          FN_SLTU:         ctrl.alu_op = ALU_SLTU;
          FN_SLL:          ctrl.alu_op = ALU_SLL;
          FN_SRL:          ctrl.alu_op = ALU_SRL;
          FN_JR: begin
            ctrl.reg_we = 1'b0;
            ctrl.jreg   = 1'b1;
          end
          default:         ctrl.reg_we = 1'b0;
        endcase
      end
      OP_J:   ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump   = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_PC4;
      end
      OP_BEQ: ctrl.br_eq = 1'b1;
      OP_BNE: ctrl.br_ne = 1'b1;
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU, OP_ANDI, OP_ORI, OP_LUI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.imm_zext = (opc == OP_ANDI) || (opc == OP_ORI);
        unique case (opc)
          OP_SLTI:  ctrl.alu_op = ALU_SLT;
          OP_SLTIU: ctrl.alu_op = ALU_SLTU;
          OP_ANDI:  ctrl.alu_op = ALU_AND;
          OP_ORI:   ctrl.alu_op = ALU_OR;
          OP_LUI:   ctrl.alu_op = ALU_LUI;
          default:  ctrl.alu_op = ALU_ADD;
        endcase
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.wb      = WB_MEM;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mrc_alu.sv
module mrc_alu
  import mrc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [4:0]     shamt,
  output logic [W-1:0]   y
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      ALU_SLL:  y = b << shamt;
      ALU_SRL:  y = b >> shamt;
      ALU_LUI:  y = {b[HALF-1:0], {HALF{1'b0}}};
      default:  y = '0;
    endcase
  end

  // R4: compare results are a single bit
  always_comb begin
    if (op == ALU_SLT || op == ALU_SLTU)
      a_r4_cmp_is_bool: assert (y[W-1:1] == '0);
  end
endmodule

// File: rtl/mrc_regfile.sv
module mrc_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] rad,
  output logic [W-1:0]  rdd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
      rdd <= '0;
    end else begin
      if (we && wa != '0) regs[wa] <= wd;
      rdd <= (rad == '0) ? '0 : regs[rad];
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mrc_core.sv
module mrc_core
  import mrc_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt,
  input  logic               imem_we,
  input  logic [IMEM_AW-1:0] imem_waddr,
  input  logic [31:0]        imem_wdata,
  input  logic [4:0]         dbg_reg_addr,
  output logic [31:0]        dbg_reg_data,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [31:0]        dbg_mem_data,
  output logic [31:0]        pc_out
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [31:0] imem [IDEPTH];
  logic [31:0] dmem [DDEPTH];
  logic [31:0] pc_q, pc_n, pc_plus4;
  logic [31:0] instr;
  ctrl_t       ctrl;
  logic [31:0] rs_val, rt_val, imm_ext, imm_sext, alu_b, alu_y, mem_rd, wb_data;
  logic [4:0]  wa;
  logic        taken, reg_we_g, mem_we_g;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_waddr] <= imem_wdata;
  end
  assign instr = imem[pc_q[IMEM_AW+1:2]];

  mrc_decode u_dec (.instr(instr), .ctrl(ctrl));

  assign imm_sext = {{16{instr[15]}}, instr[15:0]};
  assign imm_ext  = ctrl.imm_zext ? {16'b0, instr[15:0]} : imm_sext;
  assign alu_b    = ctrl.use_imm ? imm_ext : rt_val;

  mrc_alu #(.W(32)) u_alu (
    .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .shamt(instr[10:6]), .y(alu_y)
  );

  always_comb begin
    unique case (ctrl.dst)
      DST_RT:   wa = instr[20:16];
      DST_LINK: wa = 5'd31;
      default:  wa = instr[15:11];
    endcase
    unique case (ctrl.wb)
      WB_MEM:  wb_data = mem_rd;
      WB_PC4:  wb_data = pc_plus4;
      default: wb_data = alu_y;
    endcase
  end

  assign reg_we_g = ctrl.reg_we & ~halt;
  assign mem_we_g = ctrl.mem_we & ~halt;

  mrc_regfile #(.W(32), .N(32)) u_rf (
    .clk(clk), .rst(rst), .we(reg_we_g), .wa(wa), .wd(wb_data),
    .ra1(instr[25:21]), .rd1(rs_val), .ra2(instr[20:16]), .rd2(rt_val),
    .rad(dbg_reg_addr), .rdd(dbg_reg_data)
  );

  always_ff @(posedge clk) begin
    if (mem_we_g) dmem[alu_y[DMEM_AW+1:2]] <= rt_val;
    dbg_mem_data <= dmem[dbg_mem_addr];
  end
  assign mem_rd = dmem[alu_y[DMEM_AW+1:2]];

  assign pc_plus4 = pc_q + 32'd4;
  assign taken    = (ctrl.br_eq && rs_val == rt_val) || (ctrl.br_ne && rs_val != rt_val);

  always_comb begin
    if (ctrl.jreg)      pc_n = rs_val;
    else if (ctrl.jump) pc_n = {pc_plus4[31:28], instr[25:0], 2'b00};
    else if (taken)     pc_n = pc_plus4 + {imm_sext[29:0], 2'b00};
    else                pc_n = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (!halt) pc_q <= pc_n;
  end
  assign pc_out = pc_q;

  a_r1_pc_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc_q == 32'd0);

  a_r11_halt_freezes_pc: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc_q));

  a_r8_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (!halt && !taken && !ctrl.jump && !ctrl.jreg) |=> pc_q == $past(pc_q) + 32'd4);

  a_r7_store_writes_no_reg: assert property (@(posedge clk) disable iff (rst)
    ctrl.mem_we |-> !ctrl.reg_we);
endmodule

// File: tb/mrc_core_tb.sv
`timescale 1ns/1ps
module mrc_core_tb;
  localparam int IAW = 8;
  localparam int DAW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt = 1'b1;
  logic imem_we = 1'b0;
  logic [IAW-1:0] imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0]  dbg_reg_addr = '0;
  logic [31:0] dbg_reg_data;
  logic [DAW-1:0] dbg_mem_addr = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] pc_out;

  always #2.5 clk = ~clk;

  mrc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_dut (
    .clk(clk), .rst(rst), .halt(halt), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_reg_addr(dbg_reg_addr), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data), .pc_out(pc_out)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] prog [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int idx);
    return {6'(op), 26'(idx)};
  endfunction

  task automatic m_wr(logic [4:0] r, logic [31:0] v);
    if (r != 5'd0) m_reg[r] = v;
  endtask

  task automatic m_step();
    logic [31:0] ins, a, b, se, ze, nxt, ea;
    logic [5:0] op, fn;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = m_reg[ins[25:21]]; b = m_reg[ins[20:16]];
    se = {{16{ins[15]}}, ins[15:0]}; ze = {16'd0, ins[15:0]};
    nxt = m_pc + 4;
    ea = a + se;
    case (op)
      0: case (fn)
        32, 33: m_wr(ins[15:11], a + b);
        34, 35: m_wr(ins[15:11], a - b);
        36: m_wr(ins[15:11], a & b);
        37: m_wr(ins[15:11], a | b);
        39: m_wr(ins[15:11], ~(a | b));
        42: m_wr(ins[15:11], ($signed(a) < $signed(b)) ? 1 : 0);
        43: m_wr(ins[15:11], (a < b) ? 1 : 0);
        0:  m_wr(ins[15:11], b << ins[10:6]);
        2:  m_wr(ins[15:11], b >> ins[10:6]);
        8:  nxt = a;
        default: ;
      endcase
      2: nxt = {nxt[31:28], ins[25:0], 2'b00};
      3: begin m_wr(5'd31, m_pc + 4); nxt = {nxt[31:28], ins[25:0], 2'b00}; end
      4: if (a == b) nxt = nxt + (se << 2);
      5: if (a != b) nxt = nxt + (se << 2);
      8, 9: m_wr(ins[20:16], a + se);
      10: m_wr(ins[20:16], ($signed(a) < $signed(se)) ? 1 : 0);
      11: m_wr(ins[20:16], (a < se) ? 1 : 0);
      12: m_wr(ins[20:16], a & ze);
      13: m_wr(ins[20:16], a | ze);
      15: m_wr(ins[20:16], {ins[15:0], 16'd0});
      35: m_wr(ins[20:16], m_mem[ea[7:2]]);
      43: m_mem[ea[7:2]] = b;
      default: ;
    endcase
    m_pc = nxt;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = enc_i(4, 0, 0, -1);
    prog[0]  = enc_i(8, 0, 1, 5);
    prog[1]  = enc_i(8, 0, 2, -3);
    prog[2]  = enc_r(1, 2, 3, 0, 32);
    prog[3]  = enc_r(2, 1, 4, 0, 34);
    prog[4]  = enc_r(2, 1, 5, 0, 42);
    prog[5]  = enc_r(2, 1, 6, 0, 43);
    prog[6]  = enc_r(1, 2, 7, 0, 36);
    prog[7]  = enc_r(1, 2, 8, 0, 37);
    prog[8]  = enc_r(1, 2, 9, 0, 39);
    prog[9]  = enc_r(0, 1, 10, 4, 0);
    prog[10] = enc_r(0, 2, 11, 28, 2);
    prog[11] = enc_i(15, 0, 12, 'h1234);
    prog[12] = enc_i(13, 12, 12, 'h8001);
    prog[13] = enc_i(12, 2, 13, 'hFFF0);
    prog[14] = enc_i(10, 2, 14, -2);
    prog[15] = enc_i(11, 1, 15, -1);
    prog[16] = enc_i(43, 0, 12, 8);
    prog[17] = enc_i(8, 0, 16, 16);
    prog[18] = enc_i(43, 16, 4, -4);
    prog[19] = enc_i(35, 0, 17, 8);
    prog[20] = enc_i(8, 0, 0, 7);
    prog[21] = 32'hFC00_0000;
    prog[22] = enc_r(0, 0, 18, 0, 63);
    prog[23] = enc_i(4, 1, 2, 5);
    prog[24] = enc_i(5, 1, 2, 1);
    prog[25] = enc_i(8, 0, 19, 99);
    prog[26] = enc_j(3, 30);
    prog[27] = enc_i(8, 0, 20, 77);
    prog[28] = enc_j(2, 33);
    prog[29] = enc_i(8, 0, 21, 1);
    prog[30] = enc_i(9, 0, 22, 'h7FFF);
    prog[31] = enc_r(22, 22, 23, 0, 33);
    prog[32] = enc_r(31, 0, 0, 0, 8);
    prog[33] = enc_i(4, 0, 0, -1);
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_pc = '0;

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_waddr = IAW'(i); imem_wdata = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc after reset", pc_out, 32'd0);
    dbg_reg_addr = 5'd1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 register clear after reset", dbg_reg_data, 32'd0);

    for (int c = 0; c < 60; c++) begin
      halt = (c >= 10 && c < 13);
      @(posedge clk);
      if (!halt) m_step();
      @(negedge clk);
      chk(halt ? "R11 pc held while halted" : "R8/R9 pc per cycle", pc_out, m_pc);
    end
    halt = 1'b1;

    for (int r = 0; r < 32; r++) begin
      dbg_reg_addr = 5'(r);
      @(posedge clk);
      @(negedge clk);
      chk("R11 register readback", dbg_reg_data, m_reg[r]);
      case (r)
        0:  chk("R2 r0 stays zero", dbg_reg_data, 32'd0);
        3:  chk("R3 add wrap", dbg_reg_data, 32'd2);
        4:  chk("R3 sub", dbg_reg_data, 32'hFFFF_FFF8);
        5:  chk("R4 slt signed", dbg_reg_data, 32'd1);
        6:  chk("R4 sltu unsigned", dbg_reg_data, 32'd0);
        9:  chk("R3 nor", dbg_reg_data, 32'd2);
        10: chk("R5 sll", dbg_reg_data, 32'd80);
        11: chk("R5 srl zero fill", dbg_reg_data, 32'hF);
        12: chk("R6 lui then ori zero-extend", dbg_reg_data, 32'h1234_8001);
        13: chk("R6 andi zero-extend", dbg_reg_data, 32'h0000_FFF0);
        14: chk("R4 slti signed", dbg_reg_data, 32'd1);
        17: chk("R7 lw", dbg_reg_data, 32'h1234_8001);
        18: chk("R10 unknown funct writes nothing", dbg_reg_data, 32'd0);
        19: chk("R8 taken bne skips", dbg_reg_data, 32'd0);
        20: chk("R9 jr return path", dbg_reg_data, 32'd77);
        21: chk("R9 j skips", dbg_reg_data, 32'd0);
        23: chk("R6 addiu/addu", dbg_reg_data, 32'h0000_FFFE);
        31: chk("R9 jal link", dbg_reg_data, 32'd108);
        default: ;
      endcase
    end

    for (int w = 2; w < 4; w++) begin
      dbg_mem_addr = DAW'(w);
      @(posedge clk);
      @(negedge clk);
      chk("R7 sw data word", dbg_mem_data, m_mem[w]);
    end
    chk("R7 sw offset word 3 model", m_mem[3], 32'hFFFF_FFF8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule